// File: doc/BRIEF.md
# Pattern-Mismatch Input Interrupt Controller

This block watches two independent groups of four general-purpose input pins and raises an interrupt flag for a group when its chosen pins stop agreeing with a programmed reference pattern. Software picks the pins that take part through a per-bit select register. It sets the reference level of each pin through a per-bit compare register. A reference bit of 0 means the pin is expected low, so the event fires when the pin goes high. A reference bit of 1 means the pin is expected high, so the event fires when the pin goes low.

An event is the transition of the whole selected set from "every selected pin equals its reference bit" to "at least one differs". A change from one mismatching pattern to another mismatching pattern is not an event. When an event occurs, the group's flag is set whether or not the group is enabled. The group's request line is the flag gated by its enable bit, and it stays asserted until software clears the flag by writing 1 to it.

All pins pass through a two-flop synchronizer. A small synchronous register bus gives read access to the synchronized pin levels and read/write access to the control bits. Reads are combinational on the address.

Top module: `pmi_top`

## Requirements
- R1: The two groups are independent: pins 3..0 belong to group 0 and pins 7..4 to group 1, and each group has its own select, compare, enable and flag state.
- R2: A pin whose select bit is 0 has no effect on its group's event. A group with no select bit set never produces an event.
- R3: The group flag is set when the selected pins go from all matching their compare bits to at least one mismatching. The flag is visible three clock edges after the pin change is applied: two synchronizer edges, then the flag edge.
- R4: A change from one mismatch pattern to a different mismatch pattern produces no event.
- R5: A compare bit of 0 makes a low-to-high change on that selected pin an event. A compare bit of 1 makes a high-to-low change an event.
- R6: The flag is set regardless of the enable bit. irq_o[g] is high exactly while the flag and the enable bit of group g are both 1.
- R7: Writing a word with bit 0 set to a flag address clears that flag. Writing bit 0 as 0 leaves the flag unchanged. If an event and a clear reach the same flag on the same edge, the flag ends up set.
- R8: A read of a pin-data address returns the synchronized pin levels (1 = high). A write to a pin-data address changes no state.
- R9: After reset, all select, compare, enable and flag bits read 0. Unused bits of the enable and flag words, and every unmapped address, read 0.
- R10: A write to the select or compare register that turns a match into a mismatch is an event. The flag is set on the edge after the write edge.
- R11: Address map, with group g at base 4*g: base+0 is select, base+1 is pin data, base+2 is compare. The enable bit of group g is bit 0 at address 8+g. The flag of group g is bit 0 at address 10+g.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | 8 | Raw input pins, group g on bits 4g+3..4g |
| bus_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 4 | Write data |
| bus_rdata_o | output | 4 | Read data for bus_addr_i, combinational |
| irq_o | output | 2 | Per-group interrupt request level |

## Verification
A pin change is due at the read port two edges after it is applied, and at the flag three edges after it is applied. A register write is due in its register on the next edge. Any flag set caused by that write lands one edge later. The bench steps a cycle-accurate reference model on every rising edge, with the same pipeline depth. It compares irq_o and read data at the falling edge, so each result is checked in the exact cycle it is due. Directed sequences also count edges explicitly: they expect no flag one edge early and a set flag on the due edge.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
  // Register slots inside one group's address window
  localparam int unsigned SLOT_SEL = 0;
  localparam int unsigned SLOT_PIN = 1;
  localparam int unsigned SLOT_CMP = 2;
  localparam int unsigned GROUP_STRIDE = 4;

  typedef struct packed {
    logic sel_we;
    logic cmp_we;
    logic en_we;
    logic flag_we;
  } grp_wr_t;
endpackage

// File: rtl/pmi_sync.sv
module pmi_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;
  logic [W-1:0] stage1_d, stage2_d;

  always_comb begin
    stage1_d = d_i;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/pmi_group.sv
module pmi_group
  import pmi_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s_i,
  input  grp_wr_t      wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] sel_o,
  output logic [W-1:0] cmp_o,
  output logic         en_o,
  output logic         flag_o,
  output logic         evt_o,
  output logic         irq_o
);
  logic [W-1:0] sel_q, sel_d;
  logic [W-1:0] cmp_q, cmp_d;
  logic         en_q, en_d;
  logic         flag_q, flag_d;
  logic         match_q, match_now;
  logic         evt;
  logic [W-1:0] bit_ok;

  // A pin agrees when it is deselected or equals its reference bit
  always_comb begin
    bit_ok    = ~sel_q | ~(pin_s_i ^ cmp_q);
    match_now = &bit_ok;
    evt       = match_q & ~match_now;
  end

  always_comb begin
    sel_d  = sel_q;
    cmp_d  = cmp_q;
    en_d   = en_q;
    flag_d = flag_q;
    if (wr_i.sel_we) sel_d = wdata_i;
    if (wr_i.cmp_we) cmp_d = wdata_i;
    if (wr_i.en_we)  en_d  = wdata_i[0];
    // set dominates a same-cycle clear
    if (evt)
      flag_d = 1'b1;
    else if (wr_i.flag_we && wdata_i[0])
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      cmp_q   <= '0;
      en_q    <= 1'b0;
      flag_q  <= 1'b0;
      match_q <= 1'b1;
    end else begin
      sel_q   <= sel_d;
      cmp_q   <= cmp_d;
      en_q    <= en_d;
      flag_q  <= flag_d;
      match_q <= match_now;
    end
  end

  assign sel_o  = sel_q;
  assign cmp_o  = cmp_q;
  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign evt_o  = evt;
  assign irq_o  = flag_q & en_q;
endmodule

// File: rtl/pmi_top.sv
module pmi_top
  import pmi_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned GRP_W      = 4,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_GROUPS*GRP_W-1:0]   pins_i,
  input  logic                          bus_wr_i,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic [GRP_W-1:0]              bus_wdata_i,
  output logic [GRP_W-1:0]              bus_rdata_o,
  output logic [NUM_GROUPS-1:0]         irq_o
);
  localparam int unsigned PIN_W     = NUM_GROUPS * GRP_W;
  localparam int unsigned EN_BASE   = NUM_GROUPS * GROUP_STRIDE;
  localparam int unsigned FLAG_BASE = EN_BASE + NUM_GROUPS;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [PIN_W-1:0]      pin_s;
  logic [PIN_W-1:0]      grp_sel;
  logic [PIN_W-1:0]      grp_cmp;
  logic [NUM_GROUPS-1:0] grp_en;
  logic [NUM_GROUPS-1:0] grp_flag;
  logic [NUM_GROUPS-1:0] grp_evt;

  pmi_sync #(.W(PIN_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (pins_i),
    .q_o   (pin_s)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    grp_wr_t wr;
    always_comb begin
      wr.sel_we  = bus_wr_i && (bus_addr_i == ADDR_W'(g*GROUP_STRIDE + SLOT_SEL));
      wr.cmp_we  = bus_wr_i && (bus_addr_i == ADDR_W'(g*GROUP_STRIDE + SLOT_CMP));
      wr.en_we   = bus_wr_i && (bus_addr_i == ADDR_W'(EN_BASE + g));
      wr.flag_we = bus_wr_i && (bus_addr_i == ADDR_W'(FLAG_BASE + g));
    end

    pmi_group #(.W(GRP_W)) u_grp (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .pin_s_i (pin_s[g*GRP_W +: GRP_W]),
      .wr_i    (wr),
      .wdata_i (bus_wdata_i),
      .sel_o   (grp_sel[g*GRP_W +: GRP_W]),
      .cmp_o   (grp_cmp[g*GRP_W +: GRP_W]),
      .en_o    (grp_en[g]),
      .flag_o  (grp_flag[g]),
      .evt_o   (grp_evt[g]),
      .irq_o   (irq_o[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (bus_addr_i == ADDR_W'(g*GROUP_STRIDE + SLOT_SEL))
        bus_rdata_o = grp_sel[g*GRP_W +: GRP_W];
      if (bus_addr_i == ADDR_W'(g*GROUP_STRIDE + SLOT_PIN))
        bus_rdata_o = pin_s[g*GRP_W +: GRP_W];
      if (bus_addr_i == ADDR_W'(g*GROUP_STRIDE + SLOT_CMP))
        bus_rdata_o = grp_cmp[g*GRP_W +: GRP_W];
      if (bus_addr_i == ADDR_W'(EN_BASE + g))
        bus_rdata_o = {{(GRP_W-1){1'b0}}, grp_en[g]};
      if (bus_addr_i == ADDR_W'(FLAG_BASE + g))
        bus_rdata_o = {{(GRP_W-1){1'b0}}, grp_flag[g]};
    end
  end
endmodule

// File: rtl/pmi_chk.sv
module pmi_chk #(
  parameter int unsigned NG        = 2,
  parameter int unsigned GW        = 4,
  parameter int unsigned AW        = 4,
  parameter int unsigned FLAG_BASE = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          wbit0,
  input logic [NG*GW-1:0] sel,
  input logic [NG-1:0] en,
  input logic [NG-1:0] flag,
  input logic [NG-1:0] evt,
  input logic [NG-1:0] irq
);
  for (genvar g = 0; g < NG; g++) begin : g_chk
    logic clr_hit;
    assign clr_hit = bus_wr && (bus_addr == AW'(FLAG_BASE + g)) && wbit0;

    // R3: an event always leaves the flag set on the next edge
    p_evt_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> flag[g]);
    // R3: the flag only rises after an event
    p_flag_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[g]) |-> $past(evt[g]));
    // R2: nothing selected, no event
    p_no_sel_no_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[g*GW +: GW] == '0) |-> !evt[g]);
    // R6: a disabled group never requests
    p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en[g] |-> !irq[g]);
    // R7: clear without event drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !evt[g]) |=> !flag[g]);
    // R7: without a clear the flag holds
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[g] && !clr_hit) |=> flag[g]);
  end
endmodule

bind pmi_top pmi_chk #(
  .NG(NUM_GROUPS), .GW(GRP_W), .AW(ADDR_W), .FLAG_BASE(FLAG_BASE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .bus_wr   (bus_wr_i),
  .bus_addr (bus_addr_i),
  .wbit0    (bus_wdata_i[0]),
  .sel      (grp_sel),
  .en       (grp_en),
  .flag     (grp_flag),
  .evt      (grp_evt),
  .irq      (irq_o)
);

// File: tb/sim_pmi_top.sv
module sim_pmi_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] pins;
  logic       wr_en;
  logic [3:0] addr;
  logic [3:0] wdata;
  logic [3:0] rdata;
  logic [1:0] irq;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [3:0] m_sel [2];
  logic [3:0] m_cmp [2];
  logic       m_en  [2];
  logic       m_flag[2];
  logic       m_mq  [2];
  logic [7:0] m_s1, m_s2;

  pmi_top u0 (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_wr_i(wr_en),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0:  return m_sel[0];
      4'd1:  return m_s2[3:0];
      4'd2:  return m_cmp[0];
      4'd4:  return m_sel[1];
      4'd5:  return m_s2[7:4];
      4'd6:  return m_cmp[1];
      4'd8:  return {3'b0, m_en[0]};
      4'd9:  return {3'b0, m_en[1]};
      4'd10: return {3'b0, m_flag[0]};
      4'd11: return {3'b0, m_flag[1]};
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic grp_match(input int g);
    logic [3:0] p;
    p = m_s2[g*4 +: 4];
    return &(~m_sel[g] | ~(p ^ m_cmp[g]));
  endfunction

  task automatic model_reset();
    for (int g = 0; g < 2; g++) begin
      m_sel[g] = 0; m_cmp[g] = 0; m_en[g] = 0; m_flag[g] = 0; m_mq[g] = 1;
    end
    m_s1 = 0; m_s2 = 0;
  endtask

  task automatic model_step();
    logic mt [2];
    logic ev;
    for (int g = 0; g < 2; g++) mt[g] = grp_match(g);
    for (int g = 0; g < 2; g++) begin
      ev = m_mq[g] & ~mt[g];
      if (ev) m_flag[g] = 1'b1;
      else if (wr_en && addr == 4'(10 + g) && wdata[0]) m_flag[g] = 1'b0;
      if (wr_en && addr == 4'(g*4))     m_sel[g] = wdata;
      if (wr_en && addr == 4'(g*4 + 2)) m_cmp[g] = wdata;
      if (wr_en && addr == 4'(8 + g))   m_en[g]  = wdata[0];
      m_mq[g] = mt[g];
    end
    m_s2 = m_s1;
    m_s1 = pins;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({2'b0, irq}, {2'b0, m_flag[1] & m_en[1], m_flag[0] & m_en[0]}, "R6 irq");
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag);
    wr_en = 1'b0; addr = a;
    #1;
    check(rdata, exp_rd(a), tag);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    rst_n = 0; pins = 0; wr_en = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_reset();

    // R9 reset state and unmapped reads
    for (int a = 0; a < 16; a++) rd_chk(4'(a), "R9 reset read");

    // R8 pin data is read-only
    pins = 8'hA5;
    ticks(2);
    rd_chk(4'd1, "R8 pin read g0");
    rd_chk(4'd5, "R8 pin read g1");
    check(rdata, 4'hA, "R8 literal");
    wr(4'd1, 4'h0);
    wr(4'd5, 4'h3);
    rd_chk(4'd1, "R8 write ignored");
    rd_chk(4'd0, "R8 no spill sel");
    pins = 8'h0A;
    ticks(4);

    // R11/R5/R3: group0 sel 1110 cmp 1010, pins 1010 match
    wr(4'd2, 4'hA);
    wr(4'd0, 4'hE);
    wr(4'd10, 4'h1);
    rd_chk(4'd10, "R3 flag clear before run");
    check(rdata, 4'h0, "R3 flag zero");
    pins = 8'h0B;                 // unselected bit 0 toggles
    ticks(4);
    rd_chk(4'd10, "R2 unselected pin");
    check(rdata, 4'h0, "R2 no event");
    pins = 8'h03;                 // bit3 1->0 against cmp 1: falling event
    ticks(2);
    rd_chk(4'd10, "R3 not yet");
    check(rdata, 4'h0, "R3 early");
    tick();
    rd_chk(4'd10, "R3 due edge");
    check(rdata, 4'h1, "R3 set");
    rd_chk(4'd11, "R1 other group untouched");
    check(rdata, 4'h0, "R1 g1 flag");
    wr(4'd10, 4'h1);
    pins = 8'h07;                 // mismatch to another mismatch
    ticks(4);
    rd_chk(4'd10, "R4 mismatch to mismatch");
    check(rdata, 4'h0, "R4 no event");

    // R6: flag with enable 0, then enable
    pins = 8'h0A; ticks(4);
    wr(4'd10, 4'h1);
    pins = 8'h08; ticks(4);
    rd_chk(4'd10, "R6 flag set while masked");
    check(rdata, 4'h1, "R6 masked flag");
    check({2'b0, irq}, 4'h0, "R6 irq masked");
    wr(4'd8, 4'h1);
    check({2'b0, irq}, 4'h1, "R6 irq enabled");
    wr(4'd10, 4'h0);              // write 0 has no effect
    rd_chk(4'd10, "R7 write zero");
    check(rdata, 4'h1, "R7 flag kept");
    wr(4'd10, 4'h1);
    check({2'b0, irq}, 4'h0, "R7 cleared irq");

    // R5 rising on group1: sel 0001 cmp 0000
    wr(4'd4, 4'h1);
    pins = 8'h1A; ticks(3);
    rd_chk(4'd11, "R5 rising event");
    check(rdata, 4'h1, "R5 rising flag");
    wr(4'd11, 4'h1);
    wr(4'd6, 4'h1);               // now expects high: matches
    wr(4'd11, 4'h1);
    pins = 8'h0A; ticks(3);
    rd_chk(4'd11, "R5 falling event");
    check(rdata, 4'h1, "R5 falling flag");
    wr(4'd11, 4'h1);

    // R10 register rewrite creates event; R7 collision with clear
    wr(4'd6, 4'h0); ticks(1);     // pin low, cmp 0: match
    wr(4'd11, 4'h1);
    rd_chk(4'd11, "R10 precondition");
    check(rdata, 4'h0, "R10 clear");
    wr(4'd11, 4'h1);
    wr(4'd6, 4'h1);               // match becomes mismatch
    tick();
    rd_chk(4'd11, "R10 rewrite event");
    check(rdata, 4'h1, "R10 flag");
    wr(4'd6, 4'h0); ticks(1);     // back to match
    wr(4'd6, 4'h1);               // mismatch: event next edge
    wr(4'd11, 4'h1);              // clear on the event edge
    rd_chk(4'd11, "R7 set beats clear");
    check(rdata, 4'h1, "R7 collision");

    // R2 empty select never fires
    wr(4'd4, 4'h0);
    wr(4'd11, 4'h1);
    for (int i = 0; i < 20; i++) begin
      pins[7:4] = 4'($urandom_range(0, 15));
      tick();
    end
    rd_chk(4'd11, "R2 empty select");
    check(rdata, 4'h0, "R2 empty flag");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      if (r[3:0] == 0) pins = 8'($urandom);
      if (r[7:4] < 3) begin
        wr_en = 1'b1;
        addr = (r[8]) ? 4'($urandom_range(0, 15)) : 4'(r[10:9] == 0 ? 10 : r[10:9] == 1 ? 11 : r[11] ? 2 : 6);
        wdata = 4'($urandom);
      end
      tick();
      wr_en = 1'b0;
      rd_chk(4'($urandom_range(0, 15)), "R1 R11 random read");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule